// File: doc/BRIEF.md
# Flash Erase-Block Bad Marker Scanner

This block decides whether one erase block of a NAND flash device carries a factory bad marker. A start pulse supplies a block number, the number of pages per block, the spare-area size in bytes and a mode bit. The scanner then asks a separate page-read engine for the spare area of two pages of that block, one after the other. It inspects the byte stream that comes back and ends with a single-cycle done pulse that carries a bad flag and an error flag.

Two detection rules exist. In parameter-page-compliant mode (mode bit 1), the scanner reads the first and the last page of the block and flags the block as bad if any spare byte is zero. In legacy mode (mode bit 0), it reads the first and the second page and tests only spare byte 0. In both modes a bad finding on the first page skips the second read. A read that the engine reports as failed ends the scan with an error instead of a verdict.

Top module: `blk_mark_scan`

## Requirements
- R1: After reset, busy, done and req_valid are low.
- R2: The first page requested is blk_in times ppb_in; every request has req_col equal to 0 and req_len equal to spare_in.
- R3: With mode_in = 1, the second page requested is the first page plus ppb_in minus 1.
- R4: With mode_in = 1, a zero at any byte position of either page's spare stream gives a done with bad = 1.
- R5: With mode_in = 0, the second page requested is the first page plus 1.
- R6: With mode_in = 0, only the first beat (byte 0) of each stream is tested; zeros at later positions give bad = 0.
- R7: A bad finding on the first page ends the scan after that stream, with no second request; done is raised only after the beat marked rsp_last has been taken.
- R8: When both streams complete with no hit, done comes with bad = 0 and err = 0.
- R9: A beat with rsp_err = 1 ends the current stream and the scan: done comes with err = 1 and bad = 0, and no further request is made.
- R10: done is high for exactly one cycle per scan, and busy is low in that cycle.
- R11: A start pulse while busy is high is ignored: the running scan keeps its block and no extra scan follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (taken only while idle) |
| blk_in | input | BLK_W | Erase block number |
| ppb_in | input | PPB_W | Pages per block |
| spare_in | input | SP_W | Spare-area size in bytes |
| mode_in | input | 1 | 1 = compliant rule, 0 = legacy rule |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| bad | output | 1 | Block is marked bad (valid with done) |
| err | output | 1 | A spare read failed (valid with done) |
| req_valid | output | 1 | Spare read request valid |
| req_ready | input | 1 | Read engine accepts request |
| req_page | output | BLK_W+PPB_W | Page address of the request |
| req_col | output | SP_W | Column offset of the request |
| req_len | output | SP_W | Bytes requested |
| rsp_valid | input | 1 | Response byte valid |
| rsp_data | input | 8 | Response byte |
| rsp_last | input | 1 | Final byte of the stream |
| rsp_err | input | 1 | Read failed; ends the stream |

## Verification
The bench places zero bytes at the first, a middle and the final spare position, because a design that tested only byte 0 in compliant mode, or every byte in legacy mode, gives the wrong verdict on the middle-position and legacy patterns. A first-page hit is checked for a missing second request and for done that waits for the last beat; a design that stopped early would leave bytes unconsumed or raise done too soon. Errors are injected on either read, and on the first read a design that issued a second request or reported bad would be caught. A start pulse sent during a scan with a different block shows whether the block was reloaded.

// File: rtl/blk_mark_pkg.sv
package blk_mark_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RECV = 2'd2
    } scan_st_e;

    typedef enum logic {
        RULE_LEGACY    = 1'b0,
        RULE_COMPLIANT = 1'b1
    } rule_e;

    typedef struct packed {
        logic bad;
        logic err;
    } verdict_t;

    function automatic verdict_t mk_verdict(input logic is_err, input logic is_bad);
        verdict_t v;
        v.err = is_err;
        v.bad = is_bad & ~is_err;
        return v;
    endfunction

endpackage

// File: rtl/blk_mark_addr.sv
module blk_mark_addr
    import blk_mark_pkg::*;
#(
    parameter int BLK_W = 16,
    parameter int PPB_W = 10
) (
    input  logic [BLK_W-1:0]       blk,
    input  logic [PPB_W-1:0]       ppb,
    input  rule_e                  rule,
    input  logic                   second,
    output logic [BLK_W+PPB_W-1:0] page
);
    localparam int PG_W = BLK_W + PPB_W;

    logic [PG_W-1:0] base;
    logic [PG_W-1:0] step;

    always_comb begin
        base = PG_W'(blk) * PG_W'(ppb);
        if (!second)
            step = '0;
        else if (rule == RULE_COMPLIANT)
            step = PG_W'(ppb) - PG_W'(1);
        else
            step = PG_W'(1);
        page = base + step;
    end
endmodule

// File: rtl/blk_mark_judge.sv
module blk_mark_judge
    import blk_mark_pkg::*;
#(
    parameter int SP_W = 12
) (
    input  logic            beat_valid,
    input  logic [7:0]      beat_data,
    input  logic            beat_err,
    input  logic [SP_W-1:0] beat_idx,
    input  rule_e           rule,
    output logic            zero_hit
);
    logic in_window;

    always_comb begin
        in_window = (rule == RULE_COMPLIANT) || (beat_idx == '0);
        zero_hit  = beat_valid && !beat_err && in_window && (beat_data == 8'h00);
    end
endmodule

// File: rtl/blk_mark_scan.sv
module blk_mark_scan
    import blk_mark_pkg::*;
#(
    parameter int BLK_W = 16,
    parameter int PPB_W = 10,
    parameter int SP_W  = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [BLK_W-1:0]       blk_in,
    input  logic [PPB_W-1:0]       ppb_in,
    input  logic [SP_W-1:0]        spare_in,
    input  logic                   mode_in,
    output logic                   busy,
    output logic                   done,
    output logic                   bad,
    output logic                   err,
    output logic                   req_valid,
    input  logic                   req_ready,
    output logic [BLK_W+PPB_W-1:0] req_page,
    output logic [SP_W-1:0]        req_col,
    output logic [SP_W-1:0]        req_len,
    input  logic                   rsp_valid,
    input  logic [7:0]             rsp_data,
    input  logic                   rsp_last,
    input  logic                   rsp_err
);
    scan_st_e         st_q;
    logic [BLK_W-1:0] blk_q;
    logic [PPB_W-1:0] ppb_q;
    logic [SP_W-1:0]  len_q;
    rule_e            rule_q;
    logic             second_q;
    logic             hit_q;
    logic [SP_W-1:0]  idx_q;
    logic             done_q;
    verdict_t         verdict_q;
    logic             zero_hit;
    logic             stream_end;
    logic             any_hit;

    blk_mark_addr #(.BLK_W(BLK_W), .PPB_W(PPB_W)) u_addr (
        .blk    (blk_q),
        .ppb    (ppb_q),
        .rule   (rule_q),
        .second (second_q),
        .page   (req_page)
    );

    blk_mark_judge #(.SP_W(SP_W)) u_judge (
        .beat_valid (rsp_valid && st_q == ST_RECV),
        .beat_data  (rsp_data),
        .beat_err   (rsp_err),
        .beat_idx   (idx_q),
        .rule       (rule_q),
        .zero_hit   (zero_hit)
    );

    assign stream_end = rsp_valid && (rsp_last || rsp_err);
    assign any_hit    = hit_q || zero_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            blk_q     <= '0;
            ppb_q     <= '0;
            len_q     <= '0;
            rule_q    <= RULE_LEGACY;
            second_q  <= 1'b0;
            hit_q     <= 1'b0;
            idx_q     <= '0;
            done_q    <= 1'b0;
            verdict_q <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        blk_q    <= blk_in;
                        ppb_q    <= ppb_in;
                        len_q    <= spare_in;
                        rule_q   <= rule_e'(mode_in);
                        second_q <= 1'b0;
                        st_q     <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (req_ready) begin
                        idx_q <= '0;
                        hit_q <= 1'b0;
                        st_q  <= ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (rsp_valid) begin
                        idx_q <= idx_q + SP_W'(1);
                        if (zero_hit)
                            hit_q <= 1'b1;
                        if (stream_end) begin
                            if (rsp_err || any_hit || second_q) begin
                                st_q      <= ST_IDLE;
                                done_q    <= 1'b1;
                                verdict_q <= mk_verdict(rsp_err, any_hit);
                            end else begin
                                second_q <= 1'b1;
                                st_q     <= ST_REQ;
                            end
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign done      = done_q;
    assign bad       = verdict_q.bad;
    assign err       = verdict_q.err;
    assign req_valid = (st_q == ST_REQ);
    assign req_col   = '0;
    assign req_len   = len_q;
endmodule

// File: rtl/blk_mark_scan_chk.sv
module blk_mark_scan_chk #(
    parameter int BLK_W = 16,
    parameter int PPB_W = 10,
    parameter int SP_W  = 12
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic                   bad,
    input logic                   err,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [BLK_W+PPB_W-1:0] req_page,
    input logic [SP_W-1:0]        req_col,
    input logic [SP_W-1:0]        req_len
);
    // R10: completion pulse lasts one cycle and happens outside a scan
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R9: error and bad never reported together
    a_r9_err_excludes_bad: assert property (@(posedge clk) disable iff (rst)
        done |-> !(bad && err));
    // R2: request column is zero and request only inside a scan
    a_r2_col_zero: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_col == '0) && busy);
    // R2: a waiting request keeps its address and length
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_page) && $stable(req_len));
    // R11: a start during a scan does not change the pending request
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready && start |=> $stable(req_page));
endmodule

bind blk_mark_scan blk_mark_scan_chk #(.BLK_W(BLK_W), .PPB_W(PPB_W), .SP_W(SP_W)) u_chk (.*);

// File: tb/blk_mark_scan_tb.sv
module blk_mark_scan_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BLK_W = 16;
    localparam int PPB_W = 10;
    localparam int SP_W  = 12;
    localparam int PG_W  = BLK_W + PPB_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [BLK_W-1:0] blk_in = '0;
    logic [PPB_W-1:0] ppb_in = '0;
    logic [SP_W-1:0]  spare_in = '0;
    logic             mode_in = 1'b0;
    logic             busy, done, bad, err, req_valid;
    logic             req_ready = 1'b0;
    logic [PG_W-1:0]  req_page;
    logic [SP_W-1:0]  req_col, req_len;
    logic             rsp_valid = 1'b0;
    logic [7:0]       rsp_data = 8'h00;
    logic             rsp_last = 1'b0;
    logic             rsp_err = 1'b0;

    int nchk = 0;
    int nfail = 0;

    // engine model state
    int zpos [2];
    int epos [2];
    int nreq;
    int beats;
    int pg_log [4];
    int len_log [4];
    int col_log [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_mark_scan #(.BLK_W(BLK_W), .PPB_W(PPB_W), .SP_W(SP_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .blk_in(blk_in), .ppb_in(ppb_in),
        .spare_in(spare_in), .mode_in(mode_in), .busy(busy), .done(done),
        .bad(bad), .err(err), .req_valid(req_valid), .req_ready(req_ready),
        .req_page(req_page), .req_col(req_col), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .rsp_err(rsp_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // read engine: answers one request at a time with a byte stream
    initial begin
        @(negedge clk);
        forever begin
            while (!req_valid) @(negedge clk);
            req_ready = 1'b1;
            if (nreq < 4) begin
                pg_log[nreq]  = int'(req_page);
                len_log[nreq] = int'(req_len);
                col_log[nreq] = int'(req_col);
            end
            @(negedge clk);
            req_ready = 1'b0;
            for (int i = 0; i < len_log[nreq < 4 ? nreq : 3]; i++) begin
                rsp_valid = 1'b1;
                rsp_data  = 8'h5A + 8'(i);
                rsp_err   = 1'b0;
                rsp_last  = (i == len_log[nreq < 4 ? nreq : 3] - 1);
                if (nreq < 2 && zpos[nreq] == i) rsp_data = 8'h00;
                if (rsp_data == 8'h00 && !(nreq < 2 && zpos[nreq] == i)) rsp_data = 8'h11;
                if (nreq < 2 && epos[nreq] == i) begin
                    rsp_err  = 1'b1;
                    rsp_last = 1'b1;
                end
                beats++;
                @(negedge clk);
                if (rsp_err) break;
            end
            rsp_valid = 1'b0;
            rsp_last  = 1'b0;
            rsp_err   = 1'b0;
            nreq++;
        end
    end

    task automatic launch(input int b, input int p, input int s, input bit m,
                          input int z0, input int z1, input int e0, input int e1);
        zpos[0] = z0; zpos[1] = z1; epos[0] = e0; epos[1] = e1;
        nreq = 0; beats = 0;
        blk_in = BLK_W'(b); ppb_in = PPB_W'(p); spare_in = SP_W'(s); mode_in = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, {tag, " done seen"}, int'(done), 1);
    endtask

    task automatic t_reset;
        check(!busy && !done && !req_valid, "R1 reset outputs", int'({busy, done, req_valid}), 0);
    endtask

    task automatic t_compliant_good;
        launch(3, 8, 6, 1'b1, -1, -1, -1, -1);
        wait_done("R8");
        check(bad == 0 && err == 0, "R8 good verdict", int'({bad, err}), 0);
        check(nreq == 2, "R8 two reads", nreq, 2);
        check(pg_log[0] == 24, "R2 first page", pg_log[0], 24);
        check(pg_log[1] == 31, "R3 last page", pg_log[1], 31);
        check(len_log[0] == 6 && len_log[1] == 6, "R2 length", len_log[1], 6);
        check(col_log[0] == 0 && col_log[1] == 0, "R2 column", col_log[1], 0);
        check(!busy, "R10 idle at done", int'(busy), 0);
        @(negedge clk);
        check(done == 0, "R10 pulse one cycle", int'(done), 0);
    endtask

    task automatic t_compliant_mid_zero;
        launch(5, 16, 10, 1'b1, 4, -1, -1, -1);
        wait_done("R7");
        check(bad == 1 && err == 0, "R4 mid-byte zero bad", int'({bad, err}), 2);
        check(nreq == 1, "R7 no second read", nreq, 1);
        check(beats == 10, "R7 stream drained before done", beats, 10);
        check(pg_log[0] == 80, "R2 first page blk5", pg_log[0], 80);
        @(negedge clk);
    endtask

    task automatic t_compliant_tail_zero;
        launch(2, 4, 5, 1'b1, -1, 4, -1, -1);
        wait_done("R4");
        check(bad == 1, "R4 last byte of last page", int'(bad), 1);
        check(nreq == 2 && pg_log[1] == 11, "R3 last page blk2", pg_log[1], 11);
        @(negedge clk);
    endtask

    task automatic t_legacy_ignore;
        launch(3, 8, 6, 1'b0, 2, 5, -1, -1);
        wait_done("R6");
        check(bad == 0 && err == 0, "R6 later zeros ignored", int'({bad, err}), 0);
        check(nreq == 2 && pg_log[1] == 25, "R5 second page", pg_log[1], 25);
        @(negedge clk);
    endtask

    task automatic t_legacy_byte0;
        launch(7, 32, 8, 1'b0, -1, 0, -1, -1);
        wait_done("R6");
        check(bad == 1, "R6 byte0 zero second page", int'(bad), 1);
        check(pg_log[1] == 225, "R5 second page blk7", pg_log[1], 225);
        @(negedge clk);
        launch(7, 32, 8, 1'b0, 0, -1, -1, -1);
        wait_done("R7");
        check(bad == 1 && nreq == 1, "R7 legacy first-page hit", nreq, 1);
        @(negedge clk);
    endtask

    task automatic t_errors;
        launch(1, 8, 6, 1'b1, -1, -1, 2, -1);
        wait_done("R9");
        check(err == 1 && bad == 0, "R9 error first read", int'({bad, err}), 1);
        check(nreq == 1, "R9 no read after error", nreq, 1);
        @(negedge clk);
        launch(1, 8, 6, 1'b1, 1, -1, 3, -1);
        wait_done("R9");
        check(err == 1 && bad == 0, "R9 error beats zero hit", int'({bad, err}), 1);
        @(negedge clk);
        launch(1, 8, 6, 1'b0, -1, -1, -1, 0);
        wait_done("R9");
        check(err == 1 && nreq == 2, "R9 error second read", int'(err), 1);
        @(negedge clk);
    endtask

    task automatic t_busy_start;
        launch(4, 8, 6, 1'b1, -1, -1, -1, -1);
        @(negedge clk);
        blk_in = BLK_W'(9);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R11");
        check(pg_log[0] == 32 && pg_log[1] == 39, "R11 block kept", pg_log[1], 39);
        repeat (20) @(negedge clk);
        check(nreq == 2 && !busy, "R11 no extra scan", nreq, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_compliant_good();
        t_compliant_mid_zero();
        t_compliant_tail_zero();
        t_legacy_ignore();
        t_legacy_byte0();
        t_errors();
        t_busy_start();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule